// File: doc/BRIEF.md
# Texture Semaphore Issue Gate

This block controls issue between an instruction sequencer and two execution pipes, one for ALU work and one for texture fetches. Each instruction arrives with a few synchronisation flags and a gate index. The block keeps a count of outstanding texture fetches for each gate. It holds back any instruction that has to wait for a gate to drain, and any texture fetch whose coordinates depend on ALU work that is still in flight. Texture latency is tracked for a whole group of fetches under one gate, not for each register. An instruction that waits on a gate therefore waits for every fetch charged to that gate, including fetches whose results it never reads.

Instructions enter on a valid/ready stream. The sequencer raises `in_valid` with the instruction fields and must hold the valid and all fields unchanged until `in_ready` is high in the same cycle. Nothing later in program order may be presented before then. An accepted instruction produces a one-cycle issue pulse on exactly one pipe. Texture returns arrive as a strobe tagged with a gate index. The ALU pipe reports with `alu_busy` whether any issued ALU instruction has not yet retired. The number of gates is a parameter: set it to one for a single shared semaphore, or higher for independent gates.

Top module: `tsem_issue_gate`

## Requirements
- R1: An instruction is accepted when `in_valid` and `in_ready` are both high. It then pulses `alu_issue` if `in_tex`=0 or `tex_issue` if `in_tex`=1, never both. `stall` is high exactly when `in_valid` is high and `in_ready` is low.
- R2: An instruction with `in_wait`=1 is held while the gate selected by `in_sem` has any fetch outstanding. On a gate with nothing outstanding it is accepted in the same cycle, with no stall cycle.
- R3: Each accepted texture instruction adds one to its gate's outstanding count, and each `tex_ret` tagged with that gate removes one. A return takes effect from the next cycle. A waiting instruction is released only after the last outstanding fetch of its gate has returned.
- R4: A texture instruction with `in_grab`=1 closes its gate's group. Until that gate's count returns to zero, every texture instruction on that gate is held, with or without grab.
- R5: A texture instruction with `in_alu_wait`=1 is held while `alu_busy` is high.
- R6: Gates are independent. A wait on one gate is released when that gate drains, while fetches on other gates remain outstanding.
- R7: A texture issue and a return on the same gate in the same cycle leave that gate's count unchanged. This holds even at zero, and no error is raised.
- R8: A return tagged with a gate that has nothing outstanding, and no issue on that gate in the same cycle, sets `ret_err`. The flag stays set until reset.
- R9: A texture instruction on a gate whose count is at its maximum (2^CNT_W - 1) is held until a return frees a slot.
- R10: A synchronous reset (`rst`=1 at a clock edge) clears every count, every closed-group mark and `ret_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction may be accepted this cycle |
| in_tex | input | 1 | 1 = texture instruction, 0 = ALU instruction |
| in_wait | input | 1 | Wait for the selected gate to drain |
| in_grab | input | 1 | Texture only: close the group on the selected gate |
| in_alu_wait | input | 1 | Texture only: wait for ALU retirement |
| in_sem | input | SEM_W | Gate index used by the instruction |
| tex_ret | input | 1 | One texture fetch returned |
| tex_ret_sem | input | SEM_W | Gate index of the returned fetch |
| alu_busy | input | 1 | ALU pipe still holds unretired instructions |
| alu_issue | output | 1 | Issue pulse to the ALU pipe |
| tex_issue | output | 1 | Issue pulse to the texture pipe |
| stall | output | 1 | Presented instruction is being held |
| ret_err | output | 1 | Sticky: a return arrived on an empty gate |

## Verification
Some properties are checked by assertions on every cycle. At most one pipe issues, and only on a handshake. No waiting instruction issues past a busy gate. No texture instruction enters a closed group. No ALU-dependent fetch issues while the ALU is busy. The error flag is sticky, and reset clears it. Other behaviours need the bench's scenarios, because they depend on the history of counts: release happens exactly one cycle after the last return of a group, gates release independently, a same-cycle issue and return leaves the count unchanged, the counter saturates at its limit, and an underflow raises the error flag.

// File: rtl/tsem_pkg.sv
package tsem_pkg;
  typedef struct packed {
    logic tex;
    logic wait_gate;
    logic grab;
    logic alu_wait;
  } tsem_flags_t;
endpackage

// File: rtl/tsem_gate_ctr.sv
module tsem_gate_ctr #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  input  logic close_grp,
  output logic busy,
  output logic full,
  output logic closed,
  output logic underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             closed_q;

  assign busy      = (cnt_q != '0);
  assign full      = (cnt_q == CNT_MAX);
  assign closed    = closed_q;
  assign underflow = dec && !inc && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      closed_q <= 1'b0;
    end else begin
      if (inc && !dec)
        cnt_q <= cnt_q + CNT_ONE;
      else if (dec && !inc && busy)
        cnt_q <= cnt_q - CNT_ONE;

      if (inc && close_grp)
        closed_q <= 1'b1;
      else if (dec && !inc && cnt_q <= CNT_ONE)
        closed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tsem_issue_ctl.sv
module tsem_issue_ctl
  import tsem_pkg::*;
#(
  parameter int NUM_SEM = 2,
  parameter int SEM_W   = 1
) (
  input  logic               valid,
  input  tsem_flags_t        flags,
  input  logic [SEM_W-1:0]   sel,
  input  logic [NUM_SEM-1:0] gate_busy,
  input  logic [NUM_SEM-1:0] gate_full,
  input  logic [NUM_SEM-1:0] gate_closed,
  input  logic               alu_busy,
  output logic               ready,
  output logic               alu_iss,
  output logic               tex_iss,
  output logic               stall
);
  logic sel_busy, sel_full, sel_closed, block;

  always_comb begin
    sel_busy   = 1'b0;
    sel_full   = 1'b0;
    sel_closed = 1'b0;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (sel == SEM_W'(i)) begin
        sel_busy   = gate_busy[i];
        sel_full   = gate_full[i];
        sel_closed = gate_closed[i];
      end
    end
  end

  always_comb begin
    block = flags.wait_gate && sel_busy;
    if (flags.tex)
      block = block || sel_closed || sel_full || (flags.alu_wait && alu_busy);
  end

  assign ready   = !block;
  assign alu_iss = valid && ready && !flags.tex;
  assign tex_iss = valid && ready && flags.tex;
  assign stall   = valid && block;
endmodule

// File: rtl/tsem_issue_gate.sv
module tsem_issue_gate
  import tsem_pkg::*;
#(
  parameter int NUM_SEM = 2,
  parameter int CNT_W   = 3,
  localparam int SEM_W  = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_tex,
  input  logic             in_wait,
  input  logic             in_grab,
  input  logic             in_alu_wait,
  input  logic [SEM_W-1:0] in_sem,
  input  logic             tex_ret,
  input  logic [SEM_W-1:0] tex_ret_sem,
  input  logic             alu_busy,
  output logic             alu_issue,
  output logic             tex_issue,
  output logic             stall,
  output logic             ret_err
);
  tsem_flags_t        flags;
  logic [NUM_SEM-1:0] gate_busy, gate_full, gate_closed, gate_uflow;
  logic [NUM_SEM-1:0] gate_inc, gate_dec;
  logic               err_q;

  assign flags = '{tex: in_tex, wait_gate: in_wait, grab: in_grab, alu_wait: in_alu_wait};

  tsem_issue_ctl #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W)) u_ctl (
    .valid(in_valid), .flags(flags), .sel(in_sem),
    .gate_busy(gate_busy), .gate_full(gate_full), .gate_closed(gate_closed),
    .alu_busy(alu_busy), .ready(in_ready), .alu_iss(alu_issue),
    .tex_iss(tex_issue), .stall(stall)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_gate
    assign gate_inc[g] = tex_issue && (in_sem == SEM_W'(g));
    assign gate_dec[g] = tex_ret && (tex_ret_sem == SEM_W'(g));

    tsem_gate_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .inc(gate_inc[g]), .dec(gate_dec[g]),
      .close_grp(in_grab), .busy(gate_busy[g]), .full(gate_full[g]),
      .closed(gate_closed[g]), .underflow(gate_uflow[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q || (|gate_uflow);
  end

  assign ret_err = err_q;
endmodule

// File: rtl/tsem_issue_gate_chk.sv
module tsem_issue_gate_chk #(
  parameter int NUM_SEM = 2,
  parameter int SEM_W   = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_wait,
  input logic               in_alu_wait,
  input logic [SEM_W-1:0]   in_sem,
  input logic               alu_busy,
  input logic               alu_issue,
  input logic               tex_issue,
  input logic               ret_err,
  input logic [NUM_SEM-1:0] gate_busy,
  input logic [NUM_SEM-1:0] gate_closed
);
  logic sel_busy, sel_closed;
  always_comb begin
    sel_busy   = 1'b0;
    sel_closed = 1'b0;
    for (int i = 0; i < NUM_SEM; i++)
      if (in_sem == SEM_W'(i)) begin
        sel_busy   = gate_busy[i];
        sel_closed = gate_closed[i];
      end
  end

  AST_ONE_PIPE: assert property (@(posedge clk) disable iff (rst)
    !(alu_issue && tex_issue)); // R1
  AST_ISSUE_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    (alu_issue || tex_issue) |-> (in_valid && in_ready)); // R1
  AST_WAIT_GATE: assert property (@(posedge clk) disable iff (rst)
    ((alu_issue || tex_issue) && in_wait) |-> !sel_busy); // R2
  AST_CLOSED_GROUP: assert property (@(posedge clk) disable iff (rst)
    tex_issue |-> !sel_closed); // R4
  AST_ALU_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (tex_issue && in_alu_wait) |-> !alu_busy); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ret_err |=> ret_err); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !ret_err); // R10
endmodule

bind tsem_issue_gate tsem_issue_gate_chk #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_wait(in_wait), .in_alu_wait(in_alu_wait), .in_sem(in_sem),
  .alu_busy(alu_busy), .alu_issue(alu_issue), .tex_issue(tex_issue),
  .ret_err(ret_err), .gate_busy(gate_busy), .gate_closed(gate_closed)
);

// File: tb/sim_tsem_issue_gate.sv
module sim_tsem_issue_gate;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, in_ready, in_tex, in_wait, in_grab, in_alu_wait;
  logic [0:0] in_sem, tex_ret_sem;
  logic tex_ret, alu_busy, alu_issue, tex_issue, stall, ret_err;

  int n_chk = 0;
  int n_bad = 0;

  tsem_issue_gate #(.NUM_SEM(2), .CNT_W(3)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tex(in_tex), .in_wait(in_wait), .in_grab(in_grab),
    .in_alu_wait(in_alu_wait), .in_sem(in_sem), .tex_ret(tex_ret),
    .tex_ret_sem(tex_ret_sem), .alu_busy(alu_busy), .alu_issue(alu_issue),
    .tex_issue(tex_issue), .stall(stall), .ret_err(ret_err)
  );

  // stimulus bits: valid tex wait grab aluw sem ret rsem busy | ready alu tex stall
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_1_0_0_0_0_0_0_0_1_0_1_0, // tex g0
    13'b1_1_0_0_0_0_0_0_0_1_0_1_0, // tex g0
    13'b1_1_0_1_0_0_0_0_0_1_0_1_0, // tex g0 grab, count 3
    13'b1_0_1_0_0_0_0_0_0_0_0_0_1, // alu wait g0 held
    13'b1_0_1_0_0_0_1_0_0_0_0_0_1, // return 1
    13'b1_0_1_0_0_0_1_0_0_0_0_0_1, // return 2
    13'b1_0_1_0_0_0_1_0_0_0_0_0_1, // return 3, still held this cycle
    13'b1_0_1_0_0_0_0_0_0_1_1_0_0, // released
    13'b1_1_0_1_0_0_0_0_0_1_0_1_0, // tex g0 grab
    13'b1_1_0_1_0_1_0_0_0_1_0_1_0, // tex g1 grab
    13'b1_0_1_0_0_1_1_1_0_0_0_0_1, // wait g1, g1 returns
    13'b1_0_1_0_0_1_0_0_0_1_1_0_0, // g1 released while g0 busy
    13'b1_1_0_0_0_0_0_0_0_0_0_0_1, // tex into closed g0 held
    13'b1_1_0_0_0_0_1_0_0_0_0_0_1, // g0 returns
    13'b1_1_0_0_0_0_0_0_0_1_0_1_0, // tex g0 now accepted
    13'b1_1_0_0_1_1_0_0_1_0_0_0_1, // alu-wait tex, alu busy
    13'b1_1_0_0_1_1_0_0_0_1_0_1_0, // alu drained
    13'b1_0_1_0_0_0_1_0_0_0_0_0_1, // wait g0 held, g0 returns
    13'b0_0_0_0_0_0_1_1_0_1_0_0_0, // idle, g1 returns
    13'b1_0_1_0_0_1_0_0_0_1_1_0_0  // wait on empty g1 passes
  };

  task automatic drive(input logic v, t, w, g, a, s, r, rs, b);
    in_valid = v; in_tex = t; in_wait = w; in_grab = g; in_alu_wait = a;
    in_sem = s; tex_ret = r; tex_ret_sem = rs; alu_busy = b;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    // R10: after reset both gates empty, no error
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0);
    #5 check("R10 reset g0 ready", {31'd0, in_ready}, 32'd1);
    check("R10 reset err", {31'd0, ret_err}, 32'd0);
    drive(1, 0, 1, 0, 0, 1, 0, 0, 0);
    #1 check("R10 reset g1 ready", {31'd0, in_ready}, 32'd1);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      step();
      drive(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8],
            VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      #5 check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", i),
               {28'd0, in_ready, alu_issue, tex_issue, stall},
               {28'd0, VEC[i][3:0]});
    end
    step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    #5 check("R8 no error after balanced traffic", {31'd0, ret_err}, 32'd0);

    // R7: issue and return on g0 in one cycle with count 0
    step();
    drive(1, 1, 0, 0, 0, 0, 1, 0, 0);
    #5 check("R7 tex issue with same-cycle return", {31'd0, tex_issue}, 32'd1);
    step();
    drive(1, 0, 1, 0, 0, 0, 0, 0, 0);
    #5 check("R7 count unchanged, wait passes", {31'd0, alu_issue}, 32'd1);
    check("R7 no error", {31'd0, ret_err}, 32'd0);

    // R9: fill g1 to 7 outstanding, eighth held
    for (int k = 0; k < 7; k++) begin
      step();
      drive(1, 1, 0, 0, 0, 1, 0, 0, 0);
    end
    step();
    drive(1, 1, 0, 0, 0, 1, 0, 0, 0);
    #5 check("R9 full gate holds tex", {30'd0, tex_issue, stall}, 32'd1);
    step();
    drive(1, 1, 0, 0, 0, 1, 1, 1, 0);
    #5 check("R9 still held during return cycle", {31'd0, stall}, 32'd1);
    step();
    drive(1, 1, 0, 0, 0, 1, 0, 0, 0);
    #5 check("R9 slot freed, tex accepted", {31'd0, tex_issue}, 32'd1);
    for (int k = 0; k < 7; k++) begin
      step();
      drive(0, 0, 0, 0, 0, 0, 1, 1, 0);
    end
    step();
    drive(1, 0, 1, 0, 0, 1, 0, 0, 0);
    #5 check("R3 drained g1 passes wait", {31'd0, alu_issue}, 32'd1);
    check("R8 no error after drain", {31'd0, ret_err}, 32'd0);

    // R8: return on empty g0
    step();
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    #5 check("R8 error raised", {31'd0, ret_err}, 32'd1);
    step(); step(); step();
    #5 check("R8 error sticky", {31'd0, ret_err}, 32'd1);

    // R10: reset clears error and counts
    step();
    drive(1, 1, 0, 1, 0, 0, 0, 0, 0);
    step();
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step();
    rst = 1'b0;
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
    #5 check("R10 error cleared", {31'd0, ret_err}, 32'd0);
    check("R10 closed group cleared", {31'd0, tex_issue}, 32'd1);

    step();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule